// File: doc/BRIEF.md
# Cascaded Converter Timebase Prescaler

This block turns a fast parent clock into the slower timing references a sampling converter needs. A main divider produces the converter's working rate as a one-cycle enable pulse. Two further dividers count those working-rate pulses and produce a 10 µs tick and a 1 ms tick. All three ticks are clock enables in the parent clock domain, not generated clocks.

Software works out the three divide values and writes them together as one packed configuration word. Each field holds the ratio minus one, so a field of 0 divides by one. A write restarts all three counters from zero, so the new ratios apply from the next cycle. For example, with a 200 kHz working rate the slow fields are set to 1 and 199. That gives a 10 µs tick every 2 working ticks and a 1 ms tick every 200.

The block carries no data stream, so it has no valid/ready interface. The configuration strobe and the three ticks are plain level pins with no back-pressure. A parameter can remove the millisecond divider; its tick then stays low.

Top module: `adc_timebase`

## Requirements
- R1: After reset every divide field is 0, so `main_tick`, `tick_10us` and `tick_1ms` are all high in every cycle until the first write.
- R2: `main_tick` pulses once every (cfg_data[7:0] + 1) parent clock cycles.
- R3: `tick_10us` pulses on every (cfg_data[15:8] + 1)-th `main_tick`. It is only ever high in a cycle where `main_tick` is also high.
- R4: `tick_1ms` pulses on every (cfg_data[23:16] + 1)-th `main_tick`. It counts main ticks independently of `tick_10us` and is only ever high together with `main_tick`.
- R5: A cycle with `cfg_wr` high loads all three fields and clears every counter. Counting the cycle right after that clock edge as cycle 0, the first `main_tick` appears in cycle cfg_data[7:0]. Ticks already in progress under the old ratios are discarded.
- R6: A divide field of 0 makes its tick high on every enable it sees. For the main divider that is every parent cycle; for the slow dividers it is every `main_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the configuration word |
| cfg_data | input | 24 | Packed ratios minus one: [7:0] main, [15:8] 10 µs, [23:16] 1 ms |
| main_tick | output | 1 | Working-rate enable pulse |
| tick_10us | output | 1 | 10 µs enable pulse |
| tick_1ms | output | 1 | 1 ms enable pulse |

## Verification
The assertions check in every cycle that the two slow ticks only fire together with a main tick. They also check that a non-zero main ratio never gives two main ticks in a row, and that a write pushes the next main tick out by at least one cycle. The exact periods, the first-tick position after a write, the divide-by-one case and the intended 200 kHz settings can only be shown by the bench scenarios. There, a behavioural model predicts every output in every cycle, and tick counts over fixed windows are compared against hand-computed totals.

// File: rtl/adc_timebase_pkg.sv
package adc_timebase_pkg;
  localparam int unsigned DEF_MAIN_W = 8;
  localparam int unsigned DEF_US_W   = 8;
  localparam int unsigned DEF_MS_W   = 8;

  typedef enum logic [1:0] {
    STAGE_MAIN = 2'd0,
    STAGE_US   = 2'd1,
    STAGE_MS   = 2'd2
  } stage_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_timebase.sv
module adc_timebase
  import adc_timebase_pkg::*;
#(
  parameter int unsigned MAIN_W  = DEF_MAIN_W,
  parameter int unsigned US_W    = DEF_US_W,
  parameter int unsigned MS_W    = DEF_MS_W,
  parameter bit          WITH_MS = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [MAIN_W+US_W+MS_W-1:0]   cfg_data,
  output logic                          main_tick,
  output logic                          tick_10us,
  output logic                          tick_1ms
);
  localparam int unsigned US_LSB = MAIN_W;
  localparam int unsigned MS_LSB = MAIN_W + US_W;

  logic [MAIN_W-1:0] main_div_q;
  logic [US_W-1:0]   us_div_q;
  logic [MS_W-1:0]   ms_div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_div_q <= '0;
      us_div_q   <= '0;
      ms_div_q   <= '0;
    end else if (cfg_wr) begin
      main_div_q <= cfg_data[MAIN_W-1:0];
      us_div_q   <= cfg_data[US_LSB +: US_W];
      ms_div_q   <= cfg_data[MS_LSB +: MS_W];
    end
  end

  tick_divider #(.W(MAIN_W)) u_main (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(1'b1),
    .limit(main_div_q), .tick(main_tick)
  );

  tick_divider #(.W(US_W)) u_us (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(main_tick),
    .limit(us_div_q), .tick(tick_10us)
  );

  generate
    if (WITH_MS) begin : g_ms
      tick_divider #(.W(MS_W)) u_ms (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .en(main_tick),
        .limit(ms_div_q), .tick(tick_1ms)
      );
    end else begin : g_no_ms
      logic unused_ms;
      assign unused_ms = ^ms_div_q;
      assign tick_1ms  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/adc_timebase_chk.sv
module adc_timebase_chk #(
  parameter int unsigned MAIN_W = 8,
  parameter int unsigned CFG_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CFG_W-1:0]  cfg_data,
  input logic [MAIN_W-1:0] main_div,
  input logic              main_tick,
  input logic              tick_10us,
  input logic              tick_1ms
);
  // R3: slow tick rides on a main tick
  a_r3_us_on_main: assert property (@(posedge clk) disable iff (!rst_n)
    tick_10us |-> main_tick);

  // R4: millisecond tick rides on a main tick
  a_r4_ms_on_main: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1ms |-> main_tick);

  // R2: non-unity main ratio never yields back-to-back ticks
  a_r2_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    (main_tick && !cfg_wr && main_div != '0) |=> !main_tick);

  // R5: a write with non-zero main ratio restarts the count
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_data[MAIN_W-1:0] != '0) |=> !main_tick);

  // R6: unity main ratio after a write ticks at once
  a_r6_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_data[MAIN_W-1:0] == '0) |=> main_tick);
endmodule

bind adc_timebase adc_timebase_chk #(
  .MAIN_W(MAIN_W), .CFG_W(MAIN_W+US_W+MS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
  .main_div(main_div_q), .main_tick(main_tick),
  .tick_10us(tick_10us), .tick_1ms(tick_1ms)
);

// File: tb/adc_timebase_test.sv
module adc_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_data = '0;
  logic        main_tick, tick_10us, tick_1ms;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_div = 0, u_div = 0, s_div = 0;
  int m_cnt = 0, u_cnt = 0, s_cnt = 0;
  int n_main = 0, n_us = 0, n_ms = 0;

  always #2 clk = ~clk;

  adc_timebase uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .main_tick(main_tick), .tick_10us(tick_10us), .tick_1ms(tick_1ms)
  );

  function automatic bit exp_main(); return m_cnt == m_div; endfunction
  function automatic bit exp_us();   return exp_main() && u_cnt == u_div; endfunction
  function automatic bit exp_ms();   return exp_main() && s_cnt == s_div; endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; u_div = 0; s_div = 0; m_cnt = 0; u_cnt = 0; s_cnt = 0;
    end else if (cfg_wr) begin
      m_div = cfg_data[7:0]; u_div = cfg_data[15:8]; s_div = cfg_data[23:16];
      m_cnt = 0; u_cnt = 0; s_cnt = 0;
    end else if (exp_main()) begin
      u_cnt = (u_cnt == u_div) ? 0 : u_cnt + 1;
      s_cnt = (s_cnt == s_div) ? 0 : s_cnt + 1;
      m_cnt = 0;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  // lockstep comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 main_tick", main_tick, exp_main());
      check("R3 tick_10us", tick_10us, exp_us());
      check("R4 tick_1ms", tick_1ms, exp_ms());
    end
  end

  task automatic write_cfg(int ms, int us, int mn);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_data = {ms[7:0], us[7:0], mn[7:0]};
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // count ticks over n cycles; sampling starts at cycle 0 after the write edge
  task automatic run_window(int n);
    n_main = 0; n_us = 0; n_ms = 0;
    for (int k = 0; k < n; k++) begin
      n_main += main_tick; n_us += tick_10us; n_ms += tick_1ms;
      if (k < n - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset ratios are all divide-by-one
    check("R1 main after reset", main_tick, 1);
    check("R1 us after reset", tick_10us, 1);
    check("R1 ms after reset", tick_1ms, 1);

    // R5: first main tick lands in cycle main_div
    write_cfg(4, 2, 3);
    for (int k = 0; k < 4; k++) begin
      check("R5 first main tick position", main_tick, (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    write_cfg(4, 2, 3);
    run_window(60);
    check("R2 main count /4", n_main, 15);
    check("R3 us count /3", n_us, 5);
    check("R4 ms count /5", n_ms, 3);

    // R5: rewrite in mid-count discards partial progress
    repeat (2) @(negedge clk);
    write_cfg(9, 0, 0);
    run_window(30);
    check("R6 main every cycle", n_main, 30);
    check("R6 us every main", n_us, 30);
    check("R4 ms count /10", n_ms, 3);

    // intended 200 kHz style settings
    write_cfg(199, 1, 1);
    run_window(2000);
    check("R2 main count /2", n_main, 1000);
    check("R3 us count /2", n_us, 500);
    check("R4 ms count /200", n_ms, 5);

    // widest main ratio
    write_cfg(0, 0, 255);
    run_window(512);
    check("R2 main count /256", n_main, 2);
    check("R6 us every main at max", n_us, 2);

    // reset again returns to divide-by-one
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 main after second reset", main_tick, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule